// File: doc/BRIEF.md
# Partitioned Ternary-Masked CAM Array

This block is a small content-addressable memory. Every entry is one wide word made of equal segments, plus a two-bit tag that gives the entry's type. A single global setting splits each word into two parts. The low segments form the key part, which takes part in searches. The remaining upper segments form a payload part, which only stores associated data and is never searched.

A search presents a comparand and a bit mask. Any mask bit at 1 turns that bit position into a don't-care for every entry. The search matches against every entry whose tag equals the selected type. One clock later the block reports whether any entry hit, whether more than one hit, and the lowest matching address. The block also always shows the lowest free (Empty) entry and a full flag.

Entries are written at an absolute address, at the address of the last match, or at the next free entry. Entries are read back by address, and a read returns the entry's tag beside its data.

Top module: `tcam_part_array`

## Requirements
- R1: After reset every entry is tagged Empty with zero data, match, multi, match_addr, rd_data and rd_status are zero, full is 0 and free_addr is 0.
- R2: With cam_segs = n, only bits [16(n+1)-1:0] of each entry (segments 0..n) take part in a search; the upper segments are ignored.
- R3: A cmp_mask bit at 1 makes that bit position a don't-care for every entry.
- R4: Tag codes are 00 Empty, 01 Valid, 10 Skip, 11 RAM. With cmp_auto = 1 a search considers only entries tagged Valid; with cmp_auto = 0 it considers only entries whose tag equals cmp_type.
- R5: Search results (match, multi, match_addr) update at the clock edge that samples cmp_req and hold their value in every cycle without cmp_req.
- R6: match_addr is the lowest matching address, multi is 1 when two or more entries match, and all three results are zero when nothing matches.
- R7: free_addr combinationally shows the lowest address tagged Empty; full is 1, and free_addr is 0, when no entry is Empty.
- R8: wr_mode 00 writes wr_data and the tag wr_tag to entry wr_addr at the clock edge; wr_mode 11 writes nothing.
- R9: wr_mode 01 writes to the registered match_addr when match is 1; it writes nothing when match is 0.
- R10: wr_mode 10 writes to the current free_addr; it writes nothing when full is 1.
- R11: A read returns the data and the tag of entry rd_addr on rd_data and rd_status one clock after rd_req; both outputs hold their value without rd_req; a read that coincides with a write returns the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cam_segs | input | 2 | Number of key segments minus one |
| cmp_req | input | 1 | Search strobe |
| cmp_auto | input | 1 | 1: search Valid entries only |
| cmp_type | input | 2 | Tag searched when cmp_auto is 0 |
| cmp_key | input | 64 | Comparand |
| cmp_mask | input | 64 | Per-bit don't-care mask |
| wr_req | input | 1 | Write strobe |
| wr_mode | input | 2 | 00 absolute, 01 last match, 10 next free, 11 none |
| wr_addr | input | 4 | Absolute write address |
| wr_data | input | 64 | Write data |
| wr_tag | input | 2 | Tag written with the data |
| rd_req | input | 1 | Read strobe |
| rd_addr | input | 4 | Read address |
| rd_data | output | 64 | Registered read data |
| rd_status | output | 2 | Registered tag of the entry read |
| match | output | 1 | At least one entry matched |
| multi | output | 1 | Two or more entries matched |
| match_addr | output | 4 | Lowest matching address |
| free_addr | output | 4 | Lowest Empty address |
| full | output | 1 | No Empty entry exists |

## Verification
Searches are run with keys that agree with an entry only in the low segment, so that the result changes with the key-width setting alone. Masks are applied that hide exactly the differing bits, which separates masking from width. Identical keys are stored under different tags to show that the tag selects which entries can match. Duplicate keys at several addresses expose the priority order and the multi flag. The table is filled through next-free writes until full, and a seeded mix of random operations over a small key alphabet is added, so that hits, misses, dropped writes and overlapping read/write cycles all occur against the cycle-level model.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [1:0] {
    VT_EMPTY   = 2'b00,
    VT_VALID   = 2'b01,
    VT_SKIP    = 2'b10,
    VT_RAMONLY = 2'b11
  } vtag_e;

  typedef enum logic [1:0] {
    WM_ABS   = 2'b00,
    WM_MATCH = 2'b01,
    WM_FREE  = 2'b10,
    WM_NONE  = 2'b11
  } wmode_e;
endpackage

// File: rtl/cam_prio_enc.sv
module cam_prio_enc #(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic          multi,
  output logic [AW-1:0] idx
);
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) idx = AW'(i);
    end
  end

  assign any   = |vec;
  assign multi = |(vec & (vec - N'(1)));
endmodule

// File: rtl/cam_entry_cmp.sv
module cam_entry_cmp #(
  parameter int WIDTH = 64
) (
  input  logic [WIDTH-1:0] row,
  input  logic [1:0]       tag,
  input  logic [WIDTH-1:0] key,
  input  logic [WIDTH-1:0] care,
  input  logic [1:0]       sel_tag,
  output logic             hit
);
  logic tag_ok;
  logic bits_ok;

  assign tag_ok  = (tag == sel_tag);
  assign bits_ok = (((row ^ key) & care) == '0);
  assign hit     = tag_ok & bits_ok;
endmodule

// File: rtl/cam_storage.sv
module cam_storage #(
  parameter int ENTRIES = 16,
  parameter int WIDTH   = 64,
  parameter int AW      = $clog2(ENTRIES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [AW-1:0]                  waddr,
  input  logic [WIDTH-1:0]               wdata,
  input  logic [1:0]                     wtag,
  input  logic                           rd_en,
  input  logic [AW-1:0]                  raddr,
  output logic [ENTRIES-1:0][WIDTH-1:0]  row_data,
  output logic [ENTRIES-1:0][1:0]        row_tag,
  output logic [WIDTH-1:0]               rd_data,
  output logic [1:0]                     rd_tag
);
  logic [ENTRIES-1:0][WIDTH-1:0] mem_q, mem_d;
  logic [ENTRIES-1:0][1:0]       tag_q, tag_d;
  logic [WIDTH-1:0]              rdd_q, rdd_d;
  logic [1:0]                    rdt_q, rdt_d;

  always_comb begin
    mem_d = mem_q;
    tag_d = tag_q;
    rdd_d = rdd_q;
    rdt_d = rdt_q;
    if (we) begin
      mem_d[waddr] = wdata;
      tag_d[waddr] = wtag;
    end
    if (rd_en) begin
      rdd_d = mem_q[raddr];
      rdt_d = tag_q[raddr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_q <= '0;
      tag_q <= '0;
      rdd_q <= '0;
      rdt_q <= '0;
    end else begin
      mem_q <= mem_d;
      tag_q <= tag_d;
      rdd_q <= rdd_d;
      rdt_q <= rdt_d;
    end
  end

  assign row_data = mem_q;
  assign row_tag  = tag_q;
  assign rd_data  = rdd_q;
  assign rd_tag   = rdt_q;

  // R11
  rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> ($stable(rd_data) && $stable(rd_tag)));
endmodule

// File: rtl/tcam_part_array.sv
module tcam_part_array #(
  parameter int ENTRIES = 16,
  parameter int SEG_W   = 16,
  parameter int NSEG    = 4,
  parameter int AW      = $clog2(ENTRIES),
  parameter int SW      = $clog2(NSEG),
  parameter int WIDTH   = SEG_W * NSEG
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SW-1:0]    cam_segs,
  input  logic             cmp_req,
  input  logic             cmp_auto,
  input  logic [1:0]       cmp_type,
  input  logic [WIDTH-1:0] cmp_key,
  input  logic [WIDTH-1:0] cmp_mask,
  input  logic             wr_req,
  input  logic [1:0]       wr_mode,
  input  logic [AW-1:0]    wr_addr,
  input  logic [WIDTH-1:0] wr_data,
  input  logic [1:0]       wr_tag,
  input  logic             rd_req,
  input  logic [AW-1:0]    rd_addr,
  output logic [WIDTH-1:0] rd_data,
  output logic [1:0]       rd_status,
  output logic             match,
  output logic             multi,
  output logic [AW-1:0]    match_addr,
  output logic [AW-1:0]    free_addr,
  output logic             full
);
  import cam_pkg::*;

  logic [ENTRIES-1:0][WIDTH-1:0] row_data;
  logic [ENTRIES-1:0][1:0]       row_tag;
  logic [WIDTH-1:0]              seg_care;
  logic [WIDTH-1:0]              care;
  logic [1:0]                    sel_tag;
  logic [ENTRIES-1:0]            hit_vec;
  logic [ENTRIES-1:0]            empty_vec;
  logic                          hit_any, hit_multi;
  logic [AW-1:0]                 hit_idx;
  logic                          free_any;
  logic [AW-1:0]                 free_idx;
  logic                          we;
  logic [AW-1:0]                 waddr;

  logic          match_q, match_d;
  logic          multi_q, multi_d;
  logic [AW-1:0] maddr_q, maddr_d;

  // key-part selection per segment
  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_care[s*SEG_W +: SEG_W] = {SEG_W{(SW'(s) <= cam_segs)}};
  end

  assign care    = seg_care & ~cmp_mask;
  assign sel_tag = cmp_auto ? 2'(VT_VALID) : cmp_type;

  for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
    cam_entry_cmp #(.WIDTH(WIDTH)) u_cmp (
      .row     (row_data[e]),
      .tag     (row_tag[e]),
      .key     (cmp_key),
      .care    (care),
      .sel_tag (sel_tag),
      .hit     (hit_vec[e])
    );
    assign empty_vec[e] = (row_tag[e] == 2'(VT_EMPTY));
  end

  cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_hit_enc (
    .vec   (hit_vec),
    .any   (hit_any),
    .multi (hit_multi),
    .idx   (hit_idx)
  );

  logic free_multi_unused;
  cam_prio_enc #(.N(ENTRIES), .AW(AW)) u_free_enc (
    .vec   (empty_vec),
    .any   (free_any),
    .multi (free_multi_unused),
    .idx   (free_idx)
  );

  // write target resolution
  always_comb begin
    we    = 1'b0;
    waddr = wr_addr;
    case (wmode_e'(wr_mode))
      WM_ABS: begin
        we    = wr_req;
        waddr = wr_addr;
      end
      WM_MATCH: begin
        we    = wr_req & match_q;
        waddr = maddr_q;
      end
      WM_FREE: begin
        we    = wr_req & free_any;
        waddr = free_idx;
      end
      default: we = 1'b0;
    endcase
  end

  cam_storage #(.ENTRIES(ENTRIES), .WIDTH(WIDTH), .AW(AW)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .we       (we),
    .waddr    (waddr),
    .wdata    (wr_data),
    .wtag     (wr_tag),
    .rd_en    (rd_req),
    .raddr    (rd_addr),
    .row_data (row_data),
    .row_tag  (row_tag),
    .rd_data  (rd_data),
    .rd_tag   (rd_status)
  );

  // result next-state
  always_comb begin
    match_d = match_q;
    multi_d = multi_q;
    maddr_d = maddr_q;
    if (cmp_req) begin
      match_d = hit_any;
      multi_d = hit_multi;
      maddr_d = hit_idx;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      match_q <= 1'b0;
      multi_q <= 1'b0;
      maddr_q <= '0;
    end else begin
      match_q <= match_d;
      multi_q <= multi_d;
      maddr_q <= maddr_d;
    end
  end

  assign match      = match_q;
  assign multi      = multi_q;
  assign match_addr = maddr_q;
  assign free_addr  = free_idx;
  assign full       = ~free_any;

  // R6
  multi_needs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    multi |-> match);

  // R5
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_req |=> ($stable(match) && $stable(multi) && $stable(match_addr)));

  // R7
  free_is_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !full |-> (row_tag[free_addr] == 2'b00));

  // R10
  full_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_mode == 2'b10 && full) |=> $stable(row_tag));
endmodule

// File: tb/tb_tcam_part_array.sv
module tb_tcam_part_array;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cam_segs;
  logic        cmp_req, cmp_auto;
  logic [1:0]  cmp_type;
  logic [63:0] cmp_key, cmp_mask;
  logic        wr_req;
  logic [1:0]  wr_mode;
  logic [3:0]  wr_addr;
  logic [63:0] wr_data;
  logic [1:0]  wr_tag;
  logic        rd_req;
  logic [3:0]  rd_addr;
  logic [63:0] rd_data;
  logic [1:0]  rd_status;
  logic        match, multi, full;
  logic [3:0]  match_addr, free_addr;

  tcam_part_array dut (
    .clk(clk), .rst_n(rst_n), .cam_segs(cam_segs),
    .cmp_req(cmp_req), .cmp_auto(cmp_auto), .cmp_type(cmp_type),
    .cmp_key(cmp_key), .cmp_mask(cmp_mask),
    .wr_req(wr_req), .wr_mode(wr_mode), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_tag(wr_tag),
    .rd_req(rd_req), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_status(rd_status),
    .match(match), .multi(multi), .match_addr(match_addr),
    .free_addr(free_addr), .full(full)
  );

  always #10 clk = ~clk;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";

  // reference state
  logic [63:0] m_mem [N];
  logic [1:0]  m_tag [N];
  logic        m_match, m_multi;
  logic [3:0]  m_addr;
  logic [63:0] m_rdd;
  logic [1:0]  m_rdt;

  task automatic check(string what, logic [63:0] act, logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual %h expected %h", cur_req, what, act, exp);
    end
  endtask

  function automatic int model_free();
    for (int i = 0; i < N; i++) if (m_tag[i] == 2'b00) return i;
    return -1;
  endfunction

  task automatic model_reset();
    for (int i = 0; i < N; i++) begin
      m_mem[i] = '0;
      m_tag[i] = 2'b00;
    end
    m_match = 0; m_multi = 0; m_addr = 0; m_rdd = 0; m_rdt = 0;
  endtask

  task automatic model_edge();
    logic [63:0] care;
    logic [1:0]  sel;
    int          hits, first, fr, tgt;
    logic [63:0] n_rdd;
    logic [1:0]  n_rdt;
    logic        n_match, n_multi;
    logic [3:0]  n_addr;
    n_match = m_match; n_multi = m_multi; n_addr = m_addr;
    n_rdd = m_rdd; n_rdt = m_rdt;
    if (cmp_req) begin
      care = '0;
      for (int s = 0; s <= int'(cam_segs); s++) care[s*16 +: 16] = 16'hFFFF;
      care &= ~cmp_mask;
      sel = cmp_auto ? 2'b01 : cmp_type;
      hits = 0; first = 0;
      for (int i = 0; i < N; i++)
        if (m_tag[i] == sel && ((m_mem[i] ^ cmp_key) & care) == 64'd0) begin
          if (hits == 0) first = i;
          hits++;
        end
      n_match = (hits > 0);
      n_multi = (hits > 1);
      n_addr  = 4'(first);
    end
    if (rd_req) begin
      n_rdd = m_mem[rd_addr];
      n_rdt = m_tag[rd_addr];
    end
    tgt = -1;
    if (wr_req) begin
      fr = model_free();
      if (wr_mode == 2'b00) tgt = wr_addr;
      else if (wr_mode == 2'b01 && m_match) tgt = m_addr;
      else if (wr_mode == 2'b10) tgt = fr;
    end
    if (tgt >= 0) begin
      m_mem[tgt] = wr_data;
      m_tag[tgt] = wr_tag;
    end
    m_match = n_match; m_multi = n_multi; m_addr = n_addr;
    m_rdd = n_rdd; m_rdt = n_rdt;
  endtask

  task automatic compare_all();
    int fr;
    fr = model_free();
    check("match", 64'(match), 64'(m_match));
    check("multi", 64'(multi), 64'(m_multi));
    check("match_addr", 64'(match_addr), 64'(m_addr));
    check("full", 64'(full), 64'(fr < 0));
    check("free_addr", 64'(free_addr), (fr < 0) ? 64'd0 : 64'(fr));
    check("rd_data", rd_data, m_rdd);
    check("rd_status", 64'(rd_status), 64'(m_rdt));
  endtask

  task automatic clear_inputs();
    cmp_req = 0; wr_req = 0; rd_req = 0;
  endtask

  task automatic cyc();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
    clear_inputs();
  endtask

  task automatic do_write(logic [1:0] mode, logic [3:0] a, logic [63:0] d, logic [1:0] t);
    wr_req = 1; wr_mode = mode; wr_addr = a; wr_data = d; wr_tag = t;
    cyc();
  endtask

  task automatic do_cmp(logic au, logic [1:0] ty, logic [63:0] k, logic [63:0] m);
    cmp_req = 1; cmp_auto = au; cmp_type = ty; cmp_key = k; cmp_mask = m;
    cyc();
  endtask

  task automatic do_read(logic [3:0] a);
    rd_req = 1; rd_addr = a;
    cyc();
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired: actual hang expected completion");
    finish_run();
  end

  initial begin
    rst_n = 0; cam_segs = 2'd3;
    clear_inputs();
    cmp_auto = 1; cmp_type = 0; cmp_key = 0; cmp_mask = 0;
    wr_mode = 0; wr_addr = 0; wr_data = 0; wr_tag = 0; rd_addr = 0;
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    cur_req = "R1";
    compare_all();
    check("rd_status", 64'(rd_status), 64'd0);

    // R8 absolute writes, R11 reads
    cur_req = "R8";
    for (int i = 0; i < 4; i++)
      do_write(2'b00, 4'(i), {16'hA000 + 16'(i), 16'hB000, 16'hC000, 16'h1000 + 16'(i)}, 2'b01);
    do_write(2'b11, 4'd5, 64'hDEAD, 2'b01); // no-write mode
    cur_req = "R11";
    for (int i = 0; i < 6; i++) do_read(4'(i));
    rd_req = 1; rd_addr = 4'd0; wr_req = 1; wr_mode = 2'b00; wr_addr = 4'd0;
    wr_data = 64'h5555; wr_tag = 2'b01;
    cyc();  // read-during-write returns old
    do_write(2'b00, 4'd0, {16'hA000, 16'hB000, 16'hC000, 16'h1000}, 2'b01);
    repeat (2) cyc();

    // R2 key width
    cur_req = "R2";
    cam_segs = 2'd0;
    do_cmp(1, 0, {48'h0, 16'h1002}, 64'd0);
    cam_segs = 2'd1;
    do_cmp(1, 0, {32'h0, 16'hC000, 16'h1002}, 64'd0);
    cam_segs = 2'd3;
    do_cmp(1, 0, {32'h0, 16'hC000, 16'h1002}, 64'd0);
    do_cmp(1, 0, {16'hA002, 16'hB000, 16'hC000, 16'h1002}, 64'd0);

    // R3 mask
    cur_req = "R3";
    do_cmp(1, 0, {16'h0000, 16'hB000, 16'hC000, 16'h1001}, {16'hFFFF, 48'd0});
    do_cmp(1, 0, {16'hA001, 16'hB000, 16'hC000, 16'h1000}, 64'h0000_0000_0000_0003);
    do_cmp(1, 0, {16'hA001, 16'hB000, 16'hC000, 16'h1000}, 64'h0000_0000_0000_0001);

    // R4 tag selection
    cur_req = "R4";
    do_write(2'b00, 4'd6, 64'h7777_7777_7777_7777, 2'b10);
    do_write(2'b00, 4'd7, 64'h7777_7777_7777_7777, 2'b11);
    do_cmp(1, 0, 64'h7777_7777_7777_7777, 64'd0);
    do_cmp(0, 2'b10, 64'h7777_7777_7777_7777, 64'd0);
    do_cmp(0, 2'b11, 64'h7777_7777_7777_7777, 64'd0);
    do_cmp(0, 2'b01, 64'h7777_7777_7777_7777, 64'd0);

    // R6 priority and multi
    cur_req = "R6";
    do_cmp(1, 0, 64'd0, {16'h0000, 16'h0000, 16'h0000, 16'hFFFF});
    do_cmp(1, 0, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
    do_cmp(1, 0, 64'h1234, 64'd0);

    // R5 hold without strobe
    cur_req = "R5";
    do_cmp(1, 0, {16'hA003, 16'hB000, 16'hC000, 16'h1003}, 64'd0);
    cmp_key = 64'd0;
    repeat (3) cyc();

    // R9 write to last match
    cur_req = "R9";
    do_write(2'b01, 4'd0, 64'hFEED_0000_0000_1003, 2'b01);
    do_read(4'd3);
    do_cmp(1, 0, 64'h0BAD, 64'd0);
    do_write(2'b01, 4'd0, 64'hBAD0_BAD0, 2'b01);
    for (int i = 0; i < 4; i++) do_read(4'(i));

    // R7 / R10 next-free fill
    cur_req = "R10";
    for (int i = 0; i < 12; i++) do_write(2'b10, 4'd0, 64'(64'h9000 + i), 2'b01);
    cur_req = "R7";
    repeat (2) cyc();
    cur_req = "R10";
    do_write(2'b10, 4'd0, 64'hFFFF, 2'b01);
    for (int i = 0; i < N; i++) do_read(4'(i));
    cur_req = "R7";
    do_write(2'b00, 4'd9, 64'd0, 2'b00);
    do_write(2'b00, 4'd4, 64'd0, 2'b00);
    do_write(2'b10, 4'd0, 64'h4444, 2'b10);

    // mixed random traffic over a small key alphabet
    cur_req = "R6";
    for (int k = 0; k < 400; k++) begin
      int r;
      r = $urandom_range(0, 9);
      cam_segs = 2'($urandom_range(0, 3));
      if (r < 4) begin
        cmp_req = 1; cmp_auto = 1'($urandom_range(0, 1)); cmp_type = 2'($urandom_range(0, 3));
        cmp_key = {4{16'($urandom_range(0, 3))}};
        cmp_mask = ($urandom_range(0, 3) == 0) ? 64'h0000_0000_FFFF_0003 : 64'd0;
      end
      if (r >= 3 && r < 8) begin
        wr_req = 1; wr_mode = 2'($urandom_range(0, 3)); wr_addr = 4'($urandom_range(0, 15));
        wr_data = {4{16'($urandom_range(0, 3))}}; wr_tag = 2'($urandom_range(0, 3));
      end
      if (r >= 6) begin
        rd_req = 1; rd_addr = 4'($urandom_range(0, 15));
      end
      cyc();
    end

    finish_run();
  end
endmodule